// File: doc/BRIEF.md
# Autobaud Divisor Threshold Remapper

This block sits behind an autobaud detector. The detector measures the width of a start bit and hands over a raw baud divisor with a one-cycle valid strobe. The raw figure is rarely an exact standard rate. The block therefore snaps it onto a small table of programmed (threshold, divisor) pairs. A raw divisor that is at or below a pair's threshold takes that pair's substitute divisor, and the lowest matching pair wins. Thresholds are programmed in ascending order by pair index. A threshold of zero switches its pair off.

A raw divisor above every enabled threshold passes through unchanged. When the top pair's threshold is zero, the pair below it automatically becomes the top of the table, so a four-pair setup keeps working. The commit happens one clock after the strobe, and only while autobaud is armed. It loads the baud divisor output, disarms autobaud, and raises a sticky done flag. Software clears the done flag with a write-one pulse or by arming autobaud again.

Top module: `abr_remap`

## Requirements
- R1: After reset `baud_div` equals the RESET_DIV parameter (default 0), and `ab_en` and `ab_done` are both 0.
- R2: A one-cycle pulse on `ab_en_set` makes `ab_en` 1 and `ab_done` 0 from the next clock.
- R3: When `meas_valid` is 1 while `ab_en` is 1, the result appears on `baud_div` after that clock edge. At the same edge `ab_en` becomes 0 and `ab_done` becomes 1.
- R4: A `meas_valid` strobe while `ab_en` is 0 is ignored. `baud_div` and `ab_done` keep their values.
- R5: Thresholds are 0-indexed pairs packed low index first, DW bits each, in `thr_bus` and `sub_bus`. The result is the substitute divisor of the lowest-indexed enabled pair whose threshold is greater than or equal to the raw divisor. Equality counts as a match.
- R6: A pair whose threshold is zero never matches, whatever its substitute divisor holds.
- R7: When the raw divisor exceeds every enabled threshold, or no pair is enabled, the raw divisor itself is committed.
- R8: With threshold 4 at zero, threshold 3 acts as the largest. Raw divisors up to it are remapped and raw divisors above it pass through.
- R9: `ab_done` stays 1 until a `done_clr` pulse, which clears it from the next clock.
- R10: If a commit and a `done_clr` or `ab_en_set` pulse fall in the same cycle, the commit wins: `ab_done` becomes 1 and `ab_en` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_valid | input | 1 | One-cycle strobe: raw divisor is valid |
| meas_div | input | DW | Raw measured divisor |
| thr_bus | input | NPAIR*DW | Thresholds, pair 0 in the lowest bits |
| sub_bus | input | NPAIR*DW | Substitute divisors, pair 0 in the lowest bits |
| ab_en_set | input | 1 | Pulse: arm autobaud, clear done |
| done_clr | input | 1 | Pulse: write-one-to-clear of done |
| baud_div | output | DW | Committed baud divisor |
| ab_en | output | 1 | Autobaud armed; cleared by hardware on commit |
| ab_done | output | 1 | Sticky completion flag |

## Verification
The hardest situation to reach from the ports is a commit that lands in the same clock as a software pulse on `done_clr` or `ab_en_set`. Each side alone would move the flags the other way. The bench raises the strobe and the competing pulse on the same falling edge, so one rising edge samples both.

Threshold-equal raw values are the second awkward point, because a one-off error in the comparison direction hides there. Every raw value in the reduced width is swept under several tables, including disabled low pairs and the four-pair fallback, so each threshold value itself is applied.

// File: rtl/abr_pkg.sv
// Package: shared defaults for the autobaud divisor remapper.
// Assumes nothing; holds constants used by the top and its bench.
package abr_pkg;
    parameter int ABR_DW_DEF    = 16;
    parameter int ABR_NPAIR_DEF = 5;
    // Commit decision carried from the datapath to the register stage.
    typedef struct packed {
        logic commit;
        logic arm;
        logic clr;
    } abr_ctl_t;
endpackage

// File: rtl/abr_match.sv
// abr_match: one comparator per pair. Flags every pair that is enabled
// (non-zero threshold) and whose threshold is at or above the raw divisor.
// Assumes thresholds are packed low index first, DW bits each.
module abr_match #(
    parameter int DW    = 16,
    parameter int NPAIR = 5
) (
    input  logic [DW-1:0]       meas_div,
    input  logic [NPAIR*DW-1:0] thr_bus,
    output logic [NPAIR-1:0]    hit
);
    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        logic [DW-1:0] thr;
        assign thr = thr_bus[g*DW +: DW];
        // Per-pair match: enabled and not below the raw value.
        assign hit[g] = (thr != '0) && (meas_div <= thr);
    end
endmodule

// File: rtl/abr_select.sv
// abr_select: picks the substitute divisor of the lowest-indexed hit,
// or the raw divisor when nothing hit. Assumes ascending thresholds, so
// the lowest hit is the smallest enabled threshold above the raw value.
module abr_select #(
    parameter int DW    = 16,
    parameter int NPAIR = 5
) (
    input  logic [DW-1:0]       meas_div,
    input  logic [NPAIR*DW-1:0] sub_bus,
    input  logic [NPAIR-1:0]    hit,
    output logic [DW-1:0]       sel_div
);
    // Priority mux: walk from the top down so the lowest hit is kept last.
    always_comb begin
        sel_div = meas_div;
        for (int i = NPAIR - 1; i >= 0; i--) begin
            if (hit[i]) sel_div = sub_bus[i*DW +: DW];
        end
    end
endmodule

// File: rtl/abr_commit.sv
// abr_commit: state of the handshake. Holds the committed divisor, the
// armed bit and the sticky done flag. A commit outranks software pulses
// arriving in the same cycle. Synchronous active-low reset.
module abr_commit
    import abr_pkg::*;
#(
    parameter int          DW        = 16,
    parameter logic [DW-1:0] RESET_DIV = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  abr_ctl_t      ctl,
    input  logic [DW-1:0] sel_div,
    output logic [DW-1:0] baud_div,
    output logic          ab_en,
    output logic          ab_done
);
    // Divisor register: loads only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)          baud_div <= RESET_DIV;
        else if (ctl.commit) baud_div <= sel_div;
    end

    // Armed bit: hardware clear on commit, else software set.
    always_ff @(posedge clk) begin
        if (!rst_n)          ab_en <= 1'b0;
        else if (ctl.commit) ab_en <= 1'b0;
        else if (ctl.arm)    ab_en <= 1'b1;
    end

    // Done flag: set on commit, cleared by write-one or re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ab_done <= 1'b0;
        else if (ctl.commit)         ab_done <= 1'b1;
        else if (ctl.arm || ctl.clr) ab_done <= 1'b0;
    end
endmodule

// File: rtl/abr_remap.sv
// abr_remap: top of the autobaud divisor remapper. Compares the raw
// divisor against NPAIR thresholds, selects a substitute or passes the
// raw value through, and commits it one clock after the valid strobe
// while autobaud is armed. A zero top threshold leaves the next pair as
// the largest, which the per-pair enable handles without special logic.
module abr_remap
    import abr_pkg::*;
#(
    parameter int            DW        = ABR_DW_DEF,
    parameter int            NPAIR     = ABR_NPAIR_DEF,
    parameter logic [DW-1:0] RESET_DIV = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                meas_valid,
    input  logic [DW-1:0]       meas_div,
    input  logic [NPAIR*DW-1:0] thr_bus,
    input  logic [NPAIR*DW-1:0] sub_bus,
    input  logic                ab_en_set,
    input  logic                done_clr,
    output logic [DW-1:0]       baud_div,
    output logic                ab_en,
    output logic                ab_done
);
    logic [NPAIR-1:0] hit;
    logic [DW-1:0]    sel_div;
    abr_ctl_t         ctl;

    // Control decode: commit needs both the strobe and the armed bit.
    always_comb begin
        ctl.commit = meas_valid && ab_en;
        ctl.arm    = ab_en_set;
        ctl.clr    = done_clr;
    end

    abr_match #(.DW(DW), .NPAIR(NPAIR)) match_i (
        .meas_div (meas_div),
        .thr_bus  (thr_bus),
        .hit      (hit)
    );

    abr_select #(.DW(DW), .NPAIR(NPAIR)) select_i (
        .meas_div (meas_div),
        .sub_bus  (sub_bus),
        .hit      (hit),
        .sel_div  (sel_div)
    );

    abr_commit #(.DW(DW), .RESET_DIV(RESET_DIV)) commit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .sel_div  (sel_div),
        .baud_div (baud_div),
        .ab_en    (ab_en),
        .ab_done  (ab_done)
    );
endmodule

// File: rtl/abr_remap_chk.sv
// abr_remap_chk: temporal properties of the remapper, bound to the top.
// Assumes the same parameters as the instance it is bound to.
module abr_remap_chk #(
    parameter int DW    = 16,
    parameter int NPAIR = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                meas_valid,
    input logic [DW-1:0]       meas_div,
    input logic [NPAIR*DW-1:0] thr_bus,
    input logic                ab_en_set,
    input logic                done_clr,
    input logic [DW-1:0]       baud_div,
    input logic                ab_en,
    input logic                ab_done
);
    logic above_all;
    // Raw value beyond every enabled threshold (zero thresholds ignored).
    always_comb begin
        above_all = 1'b1;
        for (int i = 0; i < NPAIR; i++) begin
            if (thr_bus[i*DW +: DW] != '0 && meas_div <= thr_bus[i*DW +: DW])
                above_all = 1'b0;
        end
    end

    p_commit_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && ab_en) |=> (!ab_en && ab_done));

    p_hold_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(meas_valid && ab_en) |=> $stable(baud_div));

    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_en_set && !(meas_valid && ab_en)) |=> (ab_en && !ab_done));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_done && !done_clr && !ab_en_set) |=> ab_done);

    p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !(meas_valid && ab_en)) |=> !ab_done);

    p_passthrough_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && ab_en && above_all) |=> (baud_div == $past(meas_div)));
endmodule

bind abr_remap abr_remap_chk #(.DW(DW), .NPAIR(NPAIR)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_valid (meas_valid),
    .meas_div   (meas_div),
    .thr_bus    (thr_bus),
    .ab_en_set  (ab_en_set),
    .done_clr   (done_clr),
    .baud_div   (baud_div),
    .ab_en      (ab_en),
    .ab_done    (ab_done)
);

// File: tb/abr_remap_tb_top.sv
// Bench: sweeps every raw divisor of a 6-bit configuration under several
// threshold tables and checks the handshake corner cases.
module abr_remap_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 6;
    localparam int NP = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                meas_valid = 1'b0;
    logic [DW-1:0]       meas_div = '0;
    logic [NP*DW-1:0]    thr_bus = '0;
    logic [NP*DW-1:0]    sub_bus = '0;
    logic                ab_en_set = 1'b0;
    logic                done_clr = 1'b0;
    logic [DW-1:0]       baud_div;
    logic                ab_en;
    logic                ab_done;

    int checks = 0;
    int errors = 0;
    int thr_a [NP];
    int sub_a [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    abr_remap #(.DW(DW), .NPAIR(NP), .RESET_DIV('0)) dut_i (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_div(meas_div),
        .thr_bus(thr_bus), .sub_bus(sub_bus), .ab_en_set(ab_en_set),
        .done_clr(done_clr), .baud_div(baud_div), .ab_en(ab_en), .ab_done(ab_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_cfg(input int t0, t1, t2, t3, t4);
        thr_a[0] = t0; thr_a[1] = t1; thr_a[2] = t2; thr_a[3] = t3; thr_a[4] = t4;
        for (int i = 0; i < NP; i++) begin
            sub_a[i] = 33 + 5 * i;
            thr_bus[i*DW +: DW] = DW'(thr_a[i]);
            sub_bus[i*DW +: DW] = DW'(sub_a[i]);
        end
    endtask

    // Expected result from R5-R8: lowest enabled threshold >= raw, else raw.
    function automatic int expect_div(input int m);
        for (int i = 0; i < NP; i++)
            if (thr_a[i] != 0 && m <= thr_a[i]) return sub_a[i];
        return m;
    endfunction

    task automatic arm();
        @(negedge clk) ab_en_set = 1'b1;
        @(negedge clk) ab_en_set = 1'b0;
    endtask

    task automatic measure(input string req, input int m);
        arm();
        meas_valid = 1'b1; meas_div = DW'(m);
        @(negedge clk) meas_valid = 1'b0;
        check(req, int'(baud_div), expect_div(m));
        check("R3", int'(ab_en), 0);
        check("R3", int'(ab_done), 1);
    endtask

    task automatic sweep(input string req);
        for (int m = 0; m < (1 << DW); m++) measure(req, m);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        load_cfg(8, 16, 24, 40, 55);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", int'(baud_div), 0);
        check("R1", int'(ab_en), 0);
        check("R1", int'(ab_done), 0);

        // R2: arming sets the enable
        arm();
        check("R2", int'(ab_en), 1);
        check("R2", int'(ab_done), 0);
        @(negedge clk) meas_valid = 1'b1; meas_div = 6'd20;
        @(negedge clk) meas_valid = 1'b0;
        check("R3", int'(baud_div), 43);

        // R9: done stays sticky, then clears on write-one
        repeat (3) @(negedge clk);
        check("R9", int'(ab_done), 1);
        done_clr = 1'b1;
        @(negedge clk) done_clr = 1'b0;
        check("R9", int'(ab_done), 0);

        // R4: strobe while disarmed is ignored
        meas_valid = 1'b1; meas_div = 6'd3;
        @(negedge clk) meas_valid = 1'b0;
        check("R4", int'(baud_div), 43);
        check("R4", int'(ab_done), 0);

        // R2: re-arming clears a set done flag
        measure("R5", 9);
        arm();
        check("R2", int'(ab_done), 0);
        check("R2", int'(ab_en), 1);

        // R10: commit colliding with done_clr and ab_en_set
        meas_valid = 1'b1; meas_div = 6'd1; done_clr = 1'b1; ab_en_set = 1'b1;
        @(negedge clk) meas_valid = 1'b0; done_clr = 1'b0; ab_en_set = 1'b0;
        check("R10", int'(ab_done), 1);
        check("R10", int'(ab_en), 0);
        check("R10", int'(baud_div), 33);

        // R5/R7: all pairs enabled, full sweep
        load_cfg(8, 16, 24, 40, 55);
        sweep("R5");
        // R6: low pairs disabled with non-zero substitutes
        load_cfg(0, 0, 10, 30, 50);
        sweep("R6");
        // R8: four-pair fallback, threshold 4 zero
        load_cfg(5, 15, 25, 45, 0);
        sweep("R8");
        // R7: nothing enabled, pure passthrough
        load_cfg(0, 0, 0, 0, 0);
        sweep("R7");
        // R5: top threshold at full scale, no passthrough possible
        load_cfg(1, 2, 3, 62, 63);
        sweep("R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule